// File: doc/BRIEF.md
# DRAM Refresh Request Generator

This block keeps dynamic memory alive without processor help. A programmable divider counts pulses of a timer input and fires once every N pulses, 18 by default. Each firing raises a bus request. Once the bus is granted the block runs exactly one read cycle: it drives a 16-bit refresh address and a read strobe for one clock. No data is captured and no write strobe exists, because the only purpose of the read is to touch a row of the memory.

The refresh address comes from a sweep counter. The counter starts at a base address and steps up by one after every transfer. A separate transfer count falls by one on each transfer. On the transfer where that count is already zero, the block raises a terminal-count flag and reloads both the address and the count from their base values, so the sweep repeats indefinitely.

A small write port sets the divider reload value, the base address and the base count. It is meant to be written once at start-up, after which the block runs on its own.

Top module: `refresh_gen`

## Requirements
- R1: With `tick_in` high every cycle, successive rising edges of `bus_req` are exactly 18 cycles apart under the default reload value.
- R2: During and right after a synchronous reset, `bus_req`, `mem_rd`, `xfer_ack` and `tc` are low and `mem_addr` is 0. The first request appears on the cycle after the 18th tick edge.
- R3: `bus_req` rises on the cycle after a divider firing. It stays high until the end of the acknowledge cycle and is low on the cycle after that.
- R4: When `bus_gnt` is sampled high while a request waits, the next cycle is a single transfer cycle with `mem_rd` and `xfer_ack` both high. Every transfer is one cycle long, and no second transfer follows without a new firing.
- R5: `mem_addr` shows the sweep address during a transfer and is 0 otherwise. After reset the first address is 0, and each transfer adds one, modulo 2^16.
- R6: The transfer count resets to 0xFFFF, which gives 65536 addresses per sweep. The transfer made while the count is zero raises `tc` for that one cycle, and on the same edge the address and count reload from their base values.
- R7: A divider firing that arrives while a request is waiting or a transfer is under way is dropped. It is never queued as a second request.
- R8: A write with `cfg_sel`=0 sets the divider reload value. The new value takes effect at the divider's next reload, and values below 2 are ignored. `cfg_sel`=1 loads both the base and the current address. `cfg_sel`=2 loads both the base and the current count. `cfg_sel`=3 has no effect. A write takes priority over a transfer step on the same edge.
- R9: The divider advances only on cycles where `tick_in` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_in | input | 1 | Timer input; the divider counts cycles where it is high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target of the write: 0 divider reload, 1 base address, 2 base count, 3 none |
| cfg_data | input | 16 | Write data |
| bus_gnt | input | 1 | Bus grant |
| bus_req | output | 1 | Bus request |
| mem_addr | output | 16 | Refresh address during a transfer, 0 otherwise |
| mem_rd | output | 1 | Memory read strobe |
| xfer_ack | output | 1 | Transfer active and acknowledge flag |
| tc | output | 1 | Terminal count, high on the transfer that reloads the sweep |

## Verification
A wrong divider state shows up as a shifted `bus_req` rising edge within one refresh period. A wrong sweep address or count stays hidden until the next transfer, where `mem_addr` or `tc` differs, or until the reload at the end of the sweep. A handshake fault, such as a stuck, repeated or queued request, is visible on `bus_req` or `xfer_ack` in the very cycle it happens. A reference model compares every output on every clock, so each fault is reported at the first cycle it reaches a port.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    parameter int unsigned ADDR_W      = 16;
    parameter int unsigned DIV_W       = 16;
    parameter int unsigned CFG_W       = (ADDR_W > DIV_W) ? ADDR_W : DIV_W;
    parameter int unsigned DEF_DIVISOR = 18;
    parameter int unsigned MIN_DIVISOR = 2;

    typedef enum logic [1:0] {
        SEL_DIVISOR = 2'd0,
        SEL_BASE    = 2'd1,
        SEL_COUNT   = 2'd2,
        SEL_NONE    = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_WAIT = 2'd1,
        HS_XFER = 2'd2
    } hs_state_e;

    // Sweep position: current address and transfers left before reload
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] left;
    } sweep_t;

    // One transfer step: reload from the base values once the count is zero
    function automatic sweep_t sweep_step(input sweep_t cur, input sweep_t base);
        sweep_t nxt;
        if (cur.left == '0) begin
            nxt = base;
        end else begin
            nxt.addr = cur.addr + 1'b1;
            nxt.left = cur.left - 1'b1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/rfsh_rate_div.sv
module rfsh_rate_div #(
    parameter int unsigned DIV_W   = rfsh_pkg::DIV_W,
    parameter int unsigned DEF_DIV = rfsh_pkg::DEF_DIVISOR,
    parameter int unsigned MIN_DIV = rfsh_pkg::MIN_DIVISOR
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load_we,
    input  logic [DIV_W-1:0] load_val,
    output logic             fire
);
    localparam logic [DIV_W-1:0] DEF_V = DIV_W'(DEF_DIV);
    localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_DIV);
    localparam logic [DIV_W-1:0] ONE_V = DIV_W'(1);

    logic [DIV_W-1:0] count_q;
    logic [DIV_W-1:0] reload_q;

    // Fires on the tick that takes the count through one
    assign fire = tick && (count_q == ONE_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= DEF_V;
            reload_q <= DEF_V;
        end else begin
            if (tick) begin
                count_q <= (count_q == ONE_V) ? reload_q : count_q - 1'b1;
            end
            if (load_we && (load_val >= MIN_V)) begin
                reload_q <= load_val;
            end
        end
    end
endmodule

// File: rtl/rfsh_handshake.sv
module rfsh_handshake
    import rfsh_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic gnt,
    output logic req,
    output logic active
);
    hs_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE: if (fire) state_d = HS_WAIT;
            HS_WAIT: if (gnt)  state_d = HS_XFER;
            HS_XFER:           state_d = HS_IDLE;
            default:           state_d = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= HS_IDLE;
        else     state_q <= state_d;
    end

    assign req    = (state_q != HS_IDLE);
    assign active = (state_q == HS_XFER);
endmodule

// File: rtl/rfsh_sweep.sv
module rfsh_sweep
    import rfsh_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEF_BASE  = '0,
    parameter logic [ADDR_W-1:0] DEF_COUNT = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              base_we,
    input  logic              count_we,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    sweep_t cur_q;
    sweep_t base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.addr  <= DEF_BASE;
            cur_q.left  <= DEF_COUNT;
            base_q.addr <= DEF_BASE;
            base_q.left <= DEF_COUNT;
        end else begin
            if (step) cur_q <= sweep_step(cur_q, base_q);
            // a write overrides the step for the field it targets
            if (base_we) begin
                base_q.addr <= wdata;
                cur_q.addr  <= wdata;
            end
            if (count_we) begin
                base_q.left <= wdata;
                cur_q.left  <= wdata;
            end
        end
    end

    assign addr = cur_q.addr;
    assign last = (cur_q.left == '0);
endmodule

// File: rtl/refresh_gen.sv
module refresh_gen
    import rfsh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_in,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic              bus_gnt,
    output logic              bus_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              xfer_ack,
    output logic              tc
);
    cfg_sel_e          sel;
    logic              div_we, base_we, count_we;
    logic              fire, active, last;
    logic [ADDR_W-1:0] sweep_addr;

    assign sel      = cfg_sel_e'(cfg_sel);
    assign div_we   = cfg_we && (sel == SEL_DIVISOR);
    assign base_we  = cfg_we && (sel == SEL_BASE);
    assign count_we = cfg_we && (sel == SEL_COUNT);

    rfsh_rate_div u_div (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_in),
        .load_we  (div_we),
        .load_val (cfg_data[DIV_W-1:0]),
        .fire     (fire)
    );

    rfsh_handshake u_hs (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .gnt    (bus_gnt),
        .req    (bus_req),
        .active (active)
    );

    rfsh_sweep u_sweep (
        .clk      (clk),
        .rst      (rst),
        .step     (active),
        .base_we  (base_we),
        .count_we (count_we),
        .wdata    (cfg_data[ADDR_W-1:0]),
        .addr     (sweep_addr),
        .last     (last)
    );

    assign mem_addr = active ? sweep_addr : '0;
    assign mem_rd   = active;
    assign xfer_ack = active;
    assign tc       = active && last;
endmodule

// File: rtl/refresh_gen_chk.sv
module refresh_gen_chk
    import rfsh_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic              bus_gnt,
    input logic              bus_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              xfer_ack,
    input logic              tc
);
    logic [ADDR_W-1:0] prev_addr;
    logic              prev_tc, seen, dirty;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_addr <= '0;
            prev_tc   <= 1'b0;
            seen      <= 1'b0;
            dirty     <= 1'b0;
        end else begin
            if (xfer_ack) begin
                prev_addr <= mem_addr;
                prev_tc   <= tc;
                seen      <= 1'b1;
            end
            if (cfg_we)        dirty <= 1'b1;
            else if (xfer_ack) dirty <= 1'b0;
        end
    end

    // R4
    ack_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_ack |-> ($past(bus_gnt) && $past(bus_req)));
    // R4
    single_cycle_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_ack |=> !xfer_ack);
    // R3
    req_held_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !xfer_ack) |=> bus_req);
    // R3
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_ack |-> bus_req);
    // R6
    tc_in_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        tc |-> (xfer_ack && mem_rd));
    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_ack && seen && !prev_tc && !dirty) |-> (mem_addr == ADDR_W'(prev_addr + 1'b1)));
endmodule

bind refresh_gen refresh_gen_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .bus_gnt  (bus_gnt),
    .bus_req  (bus_req),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .xfer_ack (xfer_ack),
    .tc       (tc)
);

// File: tb/test_refresh_gen.sv
`timescale 1ns/1ps
module test_refresh_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_in = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_data = 16'd0;
    logic        bus_gnt = 1'b0;
    logic        bus_req, mem_rd, xfer_ack, tc;
    logic [15:0] mem_addr;

    always #4 clk = ~clk;

    refresh_gen i_refresh_gen (
        .clk(clk), .rst(rst), .tick_in(tick_in), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .bus_gnt(bus_gnt), .bus_req(bus_req), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .xfer_ack(xfer_ack), .tc(tc)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // ---------------- behavioural reference model ----------------
    int m_dcnt, m_load, m_st, m_addr, m_left, m_baddr, m_bleft;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_dcnt = 18; m_load = 18; m_st = 0;
            m_addr = 0; m_left = 65535; m_baddr = 0; m_bleft = 65535;
        end else begin
            bit f;
            int st_old, load_old;
            f        = tick_in && (m_dcnt == 1);
            st_old   = m_st;
            load_old = m_load;
            if (tick_in) m_dcnt = (m_dcnt == 1) ? load_old : m_dcnt - 1;
            case (st_old)
                0: if (f) m_st = 1;
                1: if (bus_gnt) m_st = 2;
                default: m_st = 0;
            endcase
            if (st_old == 2) begin
                if (m_left == 0) begin m_addr = m_baddr; m_left = m_bleft; end
                else begin m_addr = (m_addr + 1) % 65536; m_left = m_left - 1; end
            end
            if (cfg_we) begin
                if (cfg_sel == 2'd0 && cfg_data >= 2) m_load = cfg_data;
                if (cfg_sel == 2'd1) begin m_baddr = cfg_data; m_addr = cfg_data; end
                if (cfg_sel == 2'd2) begin m_bleft = cfg_data; m_left = cfg_data; end
            end
        end
    end

    // ---------------- per-cycle comparison and event capture ----------------
    int rise_q[$];
    int ack_addr_q[$];
    int ack_tc_q[$];
    bit prev_req = 0;

    always @(negedge clk) begin
        if (!rst) begin
            bit x;
            x = (m_st == 2);
            chk(bus_req == (m_st != 0), "R3", "bus_req", bus_req, m_st != 0);
            chk(xfer_ack == x && mem_rd == x, "R4", "xfer_ack/mem_rd", {xfer_ack, mem_rd}, {x, x});
            chk(mem_addr == (x ? m_addr : 0), "R5", "mem_addr", mem_addr, x ? m_addr : 0);
            chk(tc == (x && m_left == 0), "R6", "tc", tc, x && m_left == 0);
            if (bus_req && !prev_req) rise_q.push_back(cyc);
            if (xfer_ack) begin
                ack_addr_q.push_back(mem_addr);
                ack_tc_q.push_back(tc);
            end
            prev_req = bus_req;
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            report();
        end
    end

    task automatic wr(input int sel, input int data);
        cfg_we = 1; cfg_sel = 2'(sel); cfg_data = 16'(data);
        @(negedge clk);
        cfg_we = 0;
    endtask

    function automatic int last_gap();
        return rise_q[rise_q.size()-1] - rise_q[rise_q.size()-2];
    endfunction

    initial begin
        int t0, win_rise, win_ack;
        repeat (5) @(negedge clk);
        // R2: reset values
        chk(bus_req == 0 && mem_rd == 0 && xfer_ack == 0 && tc == 0, "R2", "outputs in reset",
            {bus_req, mem_rd, xfer_ack, tc}, 0);
        chk(mem_addr == 0, "R2", "mem_addr in reset", mem_addr, 0);
        rst = 0; tick_in = 1; bus_gnt = 1;
        t0 = cyc;
        @(negedge clk);
        chk(bus_req == 0, "R2", "bus_req after release", bus_req, 0);
        // R1 / R2 / R5 with default settings
        wait (rise_q.size() >= 3);
        @(negedge clk);
        chk(rise_q[0] - t0 == 18, "R2", "first request cycle", rise_q[0] - t0, 18);
        chk(rise_q[1] - rise_q[0] == 18, "R1", "period 1", rise_q[1] - rise_q[0], 18);
        chk(rise_q[2] - rise_q[1] == 18, "R1", "period 2", rise_q[2] - rise_q[1], 18);
        wait (ack_addr_q.size() >= 3);
        for (int i = 0; i < 3; i++)
            chk(ack_addr_q[i] == i, "R5", "sweep address", ack_addr_q[i], i);

        // R7: firings while the grant is withheld are dropped
        while (bus_req) @(negedge clk);
        bus_gnt = 0;
        win_rise = rise_q.size(); win_ack = ack_addr_q.size();
        repeat (70) @(negedge clk);
        chk(rise_q.size() - win_rise == 1, "R7", "requests while pending", rise_q.size() - win_rise, 1);
        chk(ack_addr_q.size() == win_ack, "R4", "no transfer without grant", ack_addr_q.size() - win_ack, 0);
        chk(bus_req == 1, "R3", "request held", bus_req, 1);
        bus_gnt = 1;
        while (!xfer_ack) @(negedge clk);
        @(negedge clk);
        chk(bus_req == 0 && xfer_ack == 0, "R7", "no queued second request", {bus_req, xfer_ack}, 0);

        // R9: divider advances only on tick
        repeat (80) begin
            tick_in = 1; @(negedge clk);
            tick_in = 0; @(negedge clk);
        end
        chk(last_gap() == 36, "R9", "period with half-rate tick", last_gap(), 36);
        tick_in = 1;

        // R8: ignored writes, then a new divisor
        wr(0, 1);
        wr(3, 16'h1234);
        repeat (60) @(negedge clk);
        chk(last_gap() == 18, "R8", "divisor 1 ignored", last_gap(), 18);
        wr(0, 5);
        repeat (50) @(negedge clk);
        chk(last_gap() == 5, "R8", "divisor 5 applied", last_gap(), 5);

        // R6 / R8: sweep reload with small count near the address wrap
        bus_gnt = 0;
        while (xfer_ack) @(negedge clk);
        @(negedge clk);
        wr(1, 16'hFFFE);
        wr(2, 2);
        ack_addr_q.delete(); ack_tc_q.delete();
        bus_gnt = 1;
        wait (ack_addr_q.size() >= 4);
        @(negedge clk);
        chk(ack_addr_q[0] == 16'hFFFE && ack_tc_q[0] == 0, "R8", "first after base write", ack_addr_q[0], 16'hFFFE);
        chk(ack_addr_q[1] == 16'hFFFF && ack_tc_q[1] == 0, "R5", "step before wrap", ack_addr_q[1], 16'hFFFF);
        chk(ack_addr_q[2] == 0 && ack_tc_q[2] == 1, "R6", "wrap with terminal count", {ack_addr_q[2], 4'(ack_tc_q[2])}, 1);
        chk(ack_addr_q[3] == 16'hFFFE && ack_tc_q[3] == 0, "R6", "reloaded base", ack_addr_q[3], 16'hFFFE);

        done = 1;
        report();
    end
endmodule